// File: doc/BRIEF.md
# Byte-packing data buffer with 16-bit port

This block is the holding store between a 16-bit register data port and a byte-wide serial engine. On the transmit side, software writes a 16-bit word that packs two bytes into the buffer. A final 8-bit write may add one last byte. The serial engine then removes the bytes one per request, oldest first. On the receive side, the serial engine delivers bytes one at a time. Software reads them back two per 16-bit read, or one when only one is left.

One control input chooses how the two bytes of a 16-bit word map to the port lanes, and the same rule applies to writes and reads. The block keeps a transmit byte count and a receive byte count, both bounded by the buffer depth. It maintains sticky status flags for transmit ready, transmit underflow, receive ready, receive overrun and single-byte read. While the enable input is low, every strobe is ignored.

Top module: `bytefifo_top`

## Requirements
- R1: After reset both byte counts are 0 and all five status flags (tx_ready, tx_underflow, rx_ready, rx_overrun, rx_single) are 0.
- R2: An accepted 16-bit write adds two bytes to the transmit buffer and raises tx_count by 2. Each serial request with tx_count above 0 presents the oldest held byte on ser_tx_data and lowers tx_count by 1. When msb_first is 1, wr_data[15:8] is sent before wr_data[7:0]; when msb_first is 0, wr_data[7:0] is sent first.
- R3: A 16-bit write while tx_count exceeds DEPTH-2 is ignored, and so is an 8-bit write while tx_count equals DEPTH. An ignored write changes neither the held bytes, nor tx_count, nor any flag.
- R4: An 8-bit write (wr_narrow=1) adds the single byte wr_data[7:0] as the last byte, without regard to msb_first. From then on, every write is ignored until tx_count returns to 0.
- R5: A serial request with tx_count 0 sets tx_underflow and tx_ready. A request that brings tx_count to 0 sets tx_ready. An accepted write clears both flags.
- R6: Received bytes are kept in arrival order. When at least two bytes are held, a read returns the two oldest and removes them. With msb_first 1 the older byte is on rd_data[15:8]; with msb_first 0 it is on rd_data[7:0]. A read of an empty buffer returns 0.
- R7: A read with exactly one byte held returns that byte in the lane the older byte would use, with the other lane 0. It sets rx_single and leaves rx_count at 0. Any other read clears rx_single.
- R8: Every received byte sets rx_ready. A byte that arrives while rx_count equals DEPTH is dropped and sets rx_overrun; the held bytes are unchanged. A read clears rx_ready and rx_overrun.
- R9: While enable is 0, writes, reads, serial requests and received bytes are ignored: the counts, the held bytes and the flags stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; when low every strobe is ignored |
| msb_first | input | 1 | Lane order of the 16-bit port |
| wr_en | input | 1 | Data-port write strobe |
| wr_narrow | input | 1 | Write is 8 bits wide (last byte) |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Data-port read strobe |
| rd_data | output | 16 | Read data for the current buffer contents |
| ser_tx_req | input | 1 | Serial engine takes one transmit byte |
| ser_tx_data | output | 8 | Oldest held transmit byte |
| ser_rx_valid | input | 1 | Serial engine delivers one received byte |
| ser_rx_data | input | 8 | Received byte |
| tx_count | output | CW (3) | Transmit bytes held |
| rx_count | output | CW (3) | Receive bytes held |
| tx_ready | output | 1 | Transmit buffer drained or underflowed |
| tx_underflow | output | 1 | Request made with no transmit byte held |
| rx_ready | output | 1 | A byte has been received since the last read |
| rx_overrun | output | 1 | A byte was dropped on a full buffer |
| rx_single | output | 1 | Last read returned a single byte |

## Verification
Transmit sweeps use both lane orders and many distinct word values. Two accepted words followed by two rejected ones separate a correct order from a swapped one, and show whether a rejected write leaves the held bytes intact. Narrow-write sequences check that the locked state blocks further writes and is released only when the buffer drains. Receive sweeps fill the buffer with zero to six bytes before reading it out: the odd counts exercise the single-byte read and the counts above the depth exercise the overrun drop. A disabled phase issues every kind of strobe, then shows that the contents held before it still come out unchanged.

// File: rtl/bytefifo_pkg.sv
package bytefifo_pkg;
  typedef logic [7:0] byte_t;

  // Place two bytes on the 16-bit port lanes; "first" is the older byte.
  function automatic logic [15:0] join_lanes(input logic hi_first, input byte_t first,
                                             input byte_t second);
    return hi_first ? {first, second} : {second, first};
  endfunction

  function automatic byte_t lane_first(input logic hi_first, input logic [15:0] w);
    return hi_first ? w[15:8] : w[7:0];
  endfunction

  function automatic byte_t lane_second(input logic hi_first, input logic [15:0] w);
    return hi_first ? w[7:0] : w[15:8];
  endfunction
endpackage

// File: rtl/bytefifo_tx.sv
module bytefifo_tx
  import bytefifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push2,
  input  logic          push1,
  input  byte_t         first,
  input  byte_t         second,
  input  logic          pop,
  output byte_t         head,
  output logic [CW-1:0] cnt,
  output logic          accept,
  output logic          underflow_ev,
  output logic          drained_ev
);
  byte_t       mem   [DEPTH];
  byte_t       n_mem [DEPTH];
  logic [CW-1:0] n_cnt;
  logic        lock, n_lock;

  always_comb begin
    n_mem        = mem;
    n_cnt        = cnt;
    n_lock       = lock;
    accept       = 1'b0;
    underflow_ev = 1'b0;
    drained_ev   = 1'b0;
    if (pop) begin
      if (cnt != '0) begin
        n_cnt = cnt - CW'(1);
        if (cnt == CW'(1)) begin
          drained_ev = 1'b1;
          n_lock     = 1'b0;
        end
      end else begin
        underflow_ev = 1'b1;
      end
    end
    // Oldest byte sits at the top filled position; new bytes enter at 0.
    if (push2 && !n_lock && (n_cnt <= CW'(DEPTH - 2))) begin
      for (int i = 2; i < DEPTH; i++) n_mem[i] = mem[i-2];
      n_mem[1] = first;
      n_mem[0] = second;
      n_cnt    = n_cnt + CW'(2);
      accept   = 1'b1;
    end else if (push1 && !n_lock && (n_cnt < CW'(DEPTH))) begin
      for (int i = 1; i < DEPTH; i++) n_mem[i] = mem[i-1];
      n_mem[0] = first;
      n_cnt    = n_cnt + CW'(1);
      n_lock   = 1'b1;
      accept   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      cnt  <= '0;
      lock <= 1'b0;
    end else begin
      mem  <= n_mem;
      cnt  <= n_cnt;
      lock <= n_lock;
    end
  end

  assign head = (cnt != '0) ? mem[AW'(cnt - CW'(1))] : '0;

  // R3: count never exceeds the depth
  p_tx_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R3: a word push into a nearly full buffer leaves count and head alone
  p_tx_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push2 && !pop && cnt > CW'(DEPTH - 2)) |=> (cnt == $past(cnt)) && $stable(head));

  // R4: once the last byte is in, further writes do not move the count
  p_tx_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && (push1 || push2) && !pop) |=> $stable(cnt));
endmodule

// File: rtl/bytefifo_rx.sv
module bytefifo_rx
  import bytefifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  byte_t         din,
  input  logic          pop,
  output byte_t         first,
  output byte_t         second,
  output logic [CW-1:0] cnt,
  output logic          overrun_ev,
  output logic          single_ev
);
  byte_t       mem   [DEPTH];
  byte_t       n_mem [DEPTH];
  logic [CW-1:0] n_cnt;

  always_comb begin
    n_mem      = mem;
    n_cnt      = cnt;
    overrun_ev = 1'b0;
    single_ev  = 1'b0;
    if (pop) begin
      if (cnt >= CW'(2)) begin
        for (int i = 0; i < DEPTH - 2; i++) n_mem[i] = mem[i+2];
        n_cnt = cnt - CW'(2);
      end else if (cnt == CW'(1)) begin
        n_cnt     = '0;
        single_ev = 1'b1;
      end
    end
    if (push) begin
      if (n_cnt < CW'(DEPTH)) begin
        n_mem[AW'(n_cnt)] = din;
        n_cnt = n_cnt + CW'(1);
      end else begin
        overrun_ev = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      cnt <= '0;
    end else begin
      mem <= n_mem;
      cnt <= n_cnt;
    end
  end

  assign first  = (cnt != '0)      ? mem[0] : '0;
  assign second = (cnt >= CW'(2))  ? mem[1] : '0;

  // R8: count never exceeds the depth
  p_rx_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R8: a byte arriving on a full buffer leaves the held bytes untouched
  p_rx_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && cnt == CW'(DEPTH)) |=> (cnt == CW'(DEPTH)) && $stable(first) && $stable(second));

  // R7: a read of a lone byte empties the buffer
  p_rx_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && cnt == CW'(1)) |=> (cnt == '0));
endmodule

// File: rtl/bytefifo_top.sv
module bytefifo_top
  import bytefifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          msb_first,
  input  logic          wr_en,
  input  logic          wr_narrow,
  input  logic [15:0]   wr_data,
  input  logic          rd_en,
  output logic [15:0]   rd_data,
  input  logic          ser_tx_req,
  output logic [7:0]    ser_tx_data,
  input  logic          ser_rx_valid,
  input  logic [7:0]    ser_rx_data,
  output logic [CW-1:0] tx_count,
  output logic [CW-1:0] rx_count,
  output logic          tx_ready,
  output logic          tx_underflow,
  output logic          rx_ready,
  output logic          rx_overrun,
  output logic          rx_single
);
  // Gated strobes and internal events, named for the checks below.
  logic  wr_word_g, wr_byte_g, tx_pop_g, rx_push_g, rd_g;
  logic  tx_accept, tx_under_ev, tx_drain_ev, rx_over_ev, rx_single_ev;
  byte_t wr_first, wr_second, rx_first, rx_second;

  assign wr_word_g = enable && wr_en && !wr_narrow;
  assign wr_byte_g = enable && wr_en && wr_narrow;
  assign tx_pop_g  = enable && ser_tx_req;
  assign rx_push_g = enable && ser_rx_valid;
  assign rd_g      = enable && rd_en;

  // A narrow write always carries its byte on the low lane.
  assign wr_first  = wr_narrow ? wr_data[7:0] : lane_first(msb_first, wr_data);
  assign wr_second = lane_second(msb_first, wr_data);

  bytefifo_tx #(.DEPTH(DEPTH)) u_tx (
    .clk, .rst_n,
    .push2(wr_word_g), .push1(wr_byte_g),
    .first(wr_first), .second(wr_second),
    .pop(tx_pop_g), .head(ser_tx_data), .cnt(tx_count),
    .accept(tx_accept), .underflow_ev(tx_under_ev), .drained_ev(tx_drain_ev)
  );

  bytefifo_rx #(.DEPTH(DEPTH)) u_rx (
    .clk, .rst_n,
    .push(rx_push_g), .din(ser_rx_data), .pop(rd_g),
    .first(rx_first), .second(rx_second), .cnt(rx_count),
    .overrun_ev(rx_over_ev), .single_ev(rx_single_ev)
  );

  assign rd_data = join_lanes(msb_first, rx_first, rx_second);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ready     <= 1'b0;
      tx_underflow <= 1'b0;
      rx_ready     <= 1'b0;
      rx_overrun   <= 1'b0;
      rx_single    <= 1'b0;
    end else begin
      if (tx_drain_ev || tx_under_ev) tx_ready <= 1'b1;
      else if (tx_accept)             tx_ready <= 1'b0;
      if (tx_under_ev)                tx_underflow <= 1'b1;
      else if (tx_accept)             tx_underflow <= 1'b0;
      if (rx_push_g)                  rx_ready <= 1'b1;
      else if (rd_g)                  rx_ready <= 1'b0;
      if (rx_over_ev)                 rx_overrun <= 1'b1;
      else if (rd_g)                  rx_overrun <= 1'b0;
      if (rd_g)                       rx_single <= rx_single_ev;
    end
  end

  // R9: a disabled block holds its counts and flags
  p_disabled_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(tx_count) && $stable(rx_count) && $stable(tx_ready) &&
                $stable(tx_underflow) && $stable(rx_ready) && $stable(rx_overrun) &&
                $stable(rx_single));

  // R5: a request on an empty transmit buffer raises underflow and ready
  p_underflow_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && ser_tx_req && tx_count == '0) |=> tx_underflow && tx_ready);

  // R8: a read with no byte arriving clears receive ready and overrun
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rd_en && !ser_rx_valid) |=> !rx_ready && !rx_overrun);
endmodule

// File: tb/test_bytefifo_top.sv
`timescale 1ns/1ps
module test_bytefifo_top;
  localparam int DEPTH = 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, enable, msb_first, wr_en, wr_narrow, rd_en, ser_tx_req, ser_rx_valid;
  logic [15:0]   wr_data, rd_data;
  logic [7:0]    ser_tx_data, ser_rx_data;
  logic [CW-1:0] tx_count, rx_count;
  logic          tx_ready, tx_underflow, rx_ready, rx_overrun, rx_single;

  bytefifo_top #(.DEPTH(DEPTH)) i_bytefifo_top (
    .clk, .rst_n, .enable, .msb_first, .wr_en, .wr_narrow, .wr_data, .rd_en, .rd_data,
    .ser_tx_req, .ser_tx_data, .ser_rx_valid, .ser_rx_data, .tx_count, .rx_count,
    .tx_ready, .tx_underflow, .rx_ready, .rx_overrun, .rx_single
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model: index 0 holds the oldest byte.
  logic [7:0] m_tx [8];
  logic [7:0] m_rx [8];
  int m_txn = 0, m_rxn = 0;
  bit m_lock = 0;
  bit f_txr = 0, f_und = 0, f_rxr = 0, f_ovr = 0, f_sgl = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    chk(tag, "tx_count", int'(tx_count), m_txn);
    chk(tag, "rx_count", int'(rx_count), m_rxn);
    chk(tag, "tx_ready", int'(tx_ready), int'(f_txr));
    chk(tag, "tx_underflow", int'(tx_underflow), int'(f_und));
    chk(tag, "rx_ready", int'(rx_ready), int'(f_rxr));
    chk(tag, "rx_overrun", int'(rx_overrun), int'(f_ovr));
    chk(tag, "rx_single", int'(rx_single), int'(f_sgl));
  endtask

  task automatic op_write(input logic [15:0] d, input bit narrow, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_narrow = narrow; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_narrow = 1'b0;
    if (enable && !m_lock) begin
      if (narrow && m_txn < DEPTH) begin
        m_tx[m_txn] = d[7:0]; m_txn += 1; m_lock = 1;
        f_txr = 0; f_und = 0;
      end else if (!narrow && m_txn <= DEPTH - 2) begin
        m_tx[m_txn]     = msb_first ? d[15:8] : d[7:0];
        m_tx[m_txn + 1] = msb_first ? d[7:0] : d[15:8];
        m_txn += 2;
        f_txr = 0; f_und = 0;
      end
    end
    check_state(tag);
  endtask

  task automatic op_pop(input string tag);
    @(negedge clk);
    ser_tx_req = 1'b1;
    #1;
    if (enable && m_txn > 0) chk(tag, "ser_tx_data", int'(ser_tx_data), int'(m_tx[0]));
    @(posedge clk); #1;
    ser_tx_req = 1'b0;
    if (enable) begin
      if (m_txn > 0) begin
        for (int i = 0; i < 7; i++) m_tx[i] = m_tx[i+1];
        m_txn -= 1;
        if (m_txn == 0) begin f_txr = 1; m_lock = 0; end
      end else begin
        f_und = 1; f_txr = 1;
      end
    end
    check_state(tag);
  endtask

  task automatic op_rx(input logic [7:0] b, input string tag);
    @(negedge clk);
    ser_rx_valid = 1'b1; ser_rx_data = b;
    @(posedge clk); #1;
    ser_rx_valid = 1'b0;
    if (enable) begin
      if (m_rxn < DEPTH) begin m_rx[m_rxn] = b; m_rxn += 1; end
      else f_ovr = 1;
      f_rxr = 1;
    end
    check_state(tag);
  endtask

  task automatic op_read(input string tag);
    logic [7:0] b0, b1;
    logic [15:0] expw;
    @(negedge clk);
    rd_en = 1'b1;
    #1;
    b0 = (m_rxn > 0) ? m_rx[0] : 8'h00;
    b1 = (m_rxn > 1) ? m_rx[1] : 8'h00;
    expw = msb_first ? {b0, b1} : {b1, b0};
    if (enable) chk(tag, "rd_data", int'(rd_data), int'(expw));
    @(posedge clk); #1;
    rd_en = 1'b0;
    if (enable) begin
      f_sgl = (m_rxn == 1);
      if (m_rxn >= 2) begin
        for (int i = 0; i < 6; i++) m_rx[i] = m_rx[i+2];
        m_rxn -= 2;
      end else m_rxn = 0;
      f_rxr = 0; f_ovr = 0;
    end
    check_state(tag);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enable = 1'b1; msb_first = 1'b0; wr_en = 1'b0; wr_narrow = 1'b0;
    wr_data = '0; rd_en = 1'b0; ser_tx_req = 1'b0; ser_rx_valid = 1'b0; ser_rx_data = '0;
    repeat (3) @(posedge clk);
    #1; check_state("R1");
    rst_n = 1'b1;
    @(posedge clk); #1; check_state("R1");

    // Transmit sweep: both lane orders, many word values, overflow and underflow.
    for (int ord = 0; ord < 2; ord++) begin
      for (int s = 0; s < 8; s++) begin
        @(negedge clk); msb_first = ord[0];
        op_write(16'(s * 16'h1357 + ord * 16'h0f0f + 16'h0102), 1'b0, "R2");
        op_write(16'(s * 16'h2468 + 16'h8071), 1'b0, "R2");
        op_write(16'hdead, 1'b0, "R3");
        op_write(16'hbeef, 1'b1, "R3");
        for (int k = 0; k < 4; k++) op_pop("R2");
        op_pop("R5");
        op_write(16'(16'h5a00 + s), 1'b0, "R5");
        op_pop("R2");
        op_pop("R5");
      end
    end

    // Narrow last-byte write and the lock it imposes.
    for (int ord = 0; ord < 2; ord++) begin
      @(negedge clk); msb_first = ord[0];
      op_write(16'h1122, 1'b0, "R4");
      op_write(16'h33c4, 1'b1, "R4");
      op_write(16'h5566, 1'b0, "R4");
      op_write(16'h7788, 1'b1, "R4");
      for (int k = 0; k < 3; k++) op_pop("R4");
      op_write(16'h99aa, 1'b0, "R4");
      op_pop("R4");
      op_pop("R4");
    end

    // Receive sweep: zero to six bytes, then read out with both lane orders.
    for (int ord = 0; ord < 2; ord++) begin
      for (int n = 0; n < 7; n++) begin
        @(negedge clk); msb_first = ord[0];
        for (int i = 0; i < n; i++) op_rx(8'(n * 16 + i + 1 + ord * 8'h80), (i >= DEPTH) ? "R8" : "R6");
        for (int k = 0; k < 3; k++) op_read((m_rxn == 1) ? "R7" : "R6");
      end
    end
    op_rx(8'h42, "R8");
    op_read("R8");
    op_read("R7");

    // Disabled block: all strobes ignored, held contents survive.
    @(negedge clk); msb_first = 1'b1;
    op_write(16'habcd, 1'b0, "R9");
    op_rx(8'he1, "R9");
    @(negedge clk); enable = 1'b0;
    op_write(16'h0f0f, 1'b0, "R9");
    op_write(16'h00f0, 1'b1, "R9");
    op_pop("R9");
    op_rx(8'he2, "R9");
    op_read("R9");
    @(negedge clk); enable = 1'b1;
    op_pop("R9");
    op_pop("R9");
    op_read("R9");

    done = 1;
    summary();
    $finish;
  end
endmodule